// File: doc/BRIEF.md
# Flash Region Access Protection Checker

This block sits beside a flash controller and judges every read, program or erase request against a set of protection registers. It asserts a deny flag in the same cycle as the request. No register stage lies between the request and the verdict. The flash array, its timing and its command sequencing belong to other blocks. This block only decides whether an access may proceed.

The protection state is held in six registers that start fully protected at reset. A write can only remove protection: each written word is ANDed into the register it selects. For program and erase in the main region, the block takes two mode inputs and applies them. The split-mode input enables the swap input. When both are set, the two physical banks trade places in the logical address map. A per-bank group register is interpreted according to whether its physical bank is currently playing logical bank 0.

Top module: `flash_prot_chk`

## Requirements
- R1: After reset every protection bit is 1. Main reads below 16384 are denied. Every main program/erase is denied. Customer-config reads at offsets 1536..2047 are denied. Log reads are denied. Program/erase of every non-main region is denied.
- R2: A register write ANDs `wr_data` into the selected register. Protection bits can be cleared but a written 1 never sets a cleared bit again.
- R3: Main reads are controlled by select 0 bits [3:0], value n. With `req_region`=0 and `req_op`=0, a read at logical address A is denied when A < n*2048. The rule applies for n in 0..8. Values 9..15 act as 8 and protect the whole first 16384 bytes.
- R4: Customer-config reads are controlled by select 1 bits [5:0], value n. With `req_region`=1 and `req_op`=0, a read at offset `req_addr[10:0]` is denied when the offset is >= 2048 - min(n,32)*16.
- R5: Select 1 bit 6 set denies reads of the log region (`req_region`=5).
- R6: Select 2 covers sectors 0..31 of logical bank 0 (`req_addr[19]`=0, sector = `req_addr[18:11]`). A set bit denies program/erase of that sector. A program/erase is any `req_op` other than 0.
- R7: For program/erase in the main region, the physical bank is `req_addr[19]` XOR (`split_mode` AND `swap`). Select 3 holds physical bank 0 and select 4 holds physical bank 1. Group = `req_addr[18:14]`, and a set bit denies the access.
- R8: Group bits 0..3 of a physical bank's register are ignored while that bank acts as logical bank 0. When the bank acts as logical bank 1, those bits apply.
- R9: With `split_mode`=0 the `swap` input has no effect on bank mapping.
- R10: Select 5 holds the non-main program/erase protection bits. Bit 0 covers customer config (region 1), bit 1 factory config (region 2), bit 2 engineering (region 3), bit 3 secure config (region 4) and bit 4 log (region 5). A set bit denies program/erase of that region.
- R11: `deny` is combinational and is 0 whenever `req_valid` is 0. Reads of regions 2, 3 and 4 are never denied. Region codes 6 and 7 are always denied.
- R12: Writes with `wr_sel` 6 or 7 change no protection state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select (0..5 valid) |
| wr_data | input | 32 | Write data, ANDed into the selected register |
| split_mode | input | 1 | Enables the bank swap |
| swap | input | 1 | Logical/physical bank swap request |
| req_valid | input | 1 | Request present |
| req_op | input | 2 | 0 read; 1, 2, 3 program/erase |
| req_region | input | 3 | 0 main, 1 customer cfg, 2 factory cfg, 3 engineering, 4 secure cfg, 5 log |
| req_addr | input | 20 | Byte address: logical main address, or region offset |
| deny | output | 1 | Access violates protection |

## Verification
The hardest state to reach is a main program/erase whose outcome depends on the mapping together with the low-group exemption. One example is a sector cleared in the per-sector register while the group bit for the same group is still set in the other physical bank. The stimulus first clears single bits, then walks the swap and split inputs through their combinations. At each combination it probes both logical banks at the same sector offsets. A long phase of randomized single-bit clears follows, with addresses biased toward the low sectors, and every cycle is compared against a behavioural model.

// File: rtl/flash_prot_pkg.sv
package flash_prot_pkg;

    localparam int WORD_W    = 32;
    localparam int SEL_W     = 3;
    localparam int OP_W      = 2;
    localparam int REGION_W  = 3;
    localparam int MAIN_RD_W = 4;
    localparam int CFG_WIN_W = 6;
    localparam int AUX_W     = 5;

    // register selects
    localparam logic [SEL_W-1:0] SEL_MAIN_RD = 3'd0;
    localparam logic [SEL_W-1:0] SEL_CFG_RD  = 3'd1;
    localparam logic [SEL_W-1:0] SEL_SECT    = 3'd2;
    localparam logic [SEL_W-1:0] SEL_GRP0    = 3'd3;
    localparam logic [SEL_W-1:0] SEL_GRP1    = 3'd4;
    localparam logic [SEL_W-1:0] SEL_AUX     = 3'd5;

    // bit of the select-1 word that guards log reads
    localparam int LOG_RD_BIT = 6;

    // auxiliary program/erase bit positions
    localparam int AUX_CUST = 0;
    localparam int AUX_FACT = 1;
    localparam int AUX_ENGR = 2;
    localparam int AUX_SECR = 3;
    localparam int AUX_LOG  = 4;

    localparam logic [OP_W-1:0] OP_READ = 2'd0;

    typedef enum logic [REGION_W-1:0] {
        RG_MAIN = 3'd0,
        RG_CUST = 3'd1,
        RG_FACT = 3'd2,
        RG_ENGR = 3'd3,
        RG_SECR = 3'd4,
        RG_LOG  = 3'd5
    } region_e;

    typedef struct packed {
        logic [MAIN_RD_W-1:0] main_rd;
        logic                 log_rd;
        logic [CFG_WIN_W-1:0] cfg_win;
        logic [WORD_W-1:0]    sect;
        logic [WORD_W-1:0]    grp0;
        logic [WORD_W-1:0]    grp1;
        logic [AUX_W-1:0]     aux;
    } prot_regs_t;

    localparam int REGS_W = $bits(prot_regs_t);

endpackage

// File: rtl/flash_prot_regs.sv
module flash_prot_regs
    import flash_prot_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [WORD_W-1:0] wr_data,
    output prot_regs_t        regs_q
);

    prot_regs_t regs_d;

    // clear-only update: new value is old value ANDed with the write data
    always_comb begin
        regs_d = regs_q;
        if (wr_en) begin
            case (wr_sel)
                SEL_MAIN_RD: regs_d.main_rd = regs_q.main_rd & wr_data[MAIN_RD_W-1:0];
                SEL_CFG_RD: begin
                    regs_d.cfg_win = regs_q.cfg_win & wr_data[CFG_WIN_W-1:0];
                    regs_d.log_rd  = regs_q.log_rd & wr_data[LOG_RD_BIT];
                end
                SEL_SECT:    regs_d.sect = regs_q.sect & wr_data;
                SEL_GRP0:    regs_d.grp0 = regs_q.grp0 & wr_data;
                SEL_GRP1:    regs_d.grp1 = regs_q.grp1 & wr_data;
                SEL_AUX:     regs_d.aux  = regs_q.aux & wr_data[AUX_W-1:0];
                default:     regs_d = regs_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '1;
        end else begin
            regs_q <= regs_d;
        end
    end

endmodule

// File: rtl/flash_prot_main.sv
module flash_prot_main
    import flash_prot_pkg::*;
#(
    parameter int SECT_LOG2          = 11,
    parameter int SECT_PER_BANK_LOG2 = 8,
    parameter int GRP_LOG2           = 3,
    parameter int RD_MAX_UNITS       = 8,
    parameter int LOW_GRP_SKIP       = 4,
    parameter int ADDR_W             = SECT_LOG2 + SECT_PER_BANK_LOG2 + 1
)(
    input  logic [ADDR_W-1:0]    addr,
    input  logic                 is_read,
    input  logic                 split_mode,
    input  logic                 swap,
    input  logic [MAIN_RD_W-1:0] main_rd,
    input  logic [WORD_W-1:0]    sect_prot,
    input  logic [WORD_W-1:0]    grp0_prot,
    input  logic [WORD_W-1:0]    grp1_prot,
    output logic                 deny
);

    localparam int BANK_AW = SECT_LOG2 + SECT_PER_BANK_LOG2;
    localparam int SECT_W  = SECT_PER_BANK_LOG2;
    localparam int GRP_W   = SECT_PER_BANK_LOG2 - GRP_LOG2;
    localparam int SIDX_W  = $clog2(WORD_W);

    logic                 log_bank;
    logic                 eff_swap;
    logic                 phys_bank;
    logic                 phys_is_l0;
    logic [SECT_W-1:0]    sect;
    logic [GRP_W-1:0]     grp;
    logic [MAIN_RD_W-1:0] units;
    logic [ADDR_W:0]      rd_limit;
    logic                 sect_hit;
    logic                 grp_bit;
    logic                 grp_hit;

    always_comb begin
        log_bank   = addr[ADDR_W-1];
        sect       = addr[BANK_AW-1:SECT_LOG2];
        grp        = sect[SECT_W-1:GRP_LOG2];
        eff_swap   = split_mode & swap;
        phys_bank  = log_bank ^ eff_swap;
        // physical bank n plays logical bank 0 when the effective swap equals n
        phys_is_l0 = (phys_bank == eff_swap);

        // read window: undefined codes saturate to the full window
        units    = (main_rd > MAIN_RD_W'(RD_MAX_UNITS)) ? MAIN_RD_W'(RD_MAX_UNITS) : main_rd;
        rd_limit = (ADDR_W + 1)'(units) << SECT_LOG2;

        sect_hit = !log_bank && (int'(sect) < WORD_W) && sect_prot[sect[SIDX_W-1:0]];
        grp_bit  = phys_bank ? grp1_prot[grp] : grp0_prot[grp];
        grp_hit  = grp_bit && !(phys_is_l0 && (int'(grp) < LOW_GRP_SKIP));

        if (is_read) begin
            deny = ({1'b0, addr} < rd_limit);
        end else begin
            deny = sect_hit | grp_hit;
        end
    end

endmodule

// File: rtl/flash_prot_cfg.sv
module flash_prot_cfg
    import flash_prot_pkg::*;
#(
    parameter int CFG_AW    = 11,
    parameter int STEP_LOG2 = 4,
    parameter int WIN_STEPS = 32
)(
    input  logic [CFG_AW-1:0]    cfg_off,
    input  logic                 is_read,
    input  logic [REGION_W-1:0]  region,
    input  logic [CFG_WIN_W-1:0] cfg_win,
    input  logic                 log_rd,
    input  logic [AUX_W-1:0]     aux,
    output logic                 deny
);

    localparam logic [CFG_AW:0] REGION_END = (CFG_AW + 1)'(1) << CFG_AW;

    logic [CFG_WIN_W-1:0] steps;
    logic [CFG_AW:0]      floor_off;
    logic                 win_hit;

    always_comb begin
        steps     = (cfg_win > CFG_WIN_W'(WIN_STEPS)) ? CFG_WIN_W'(WIN_STEPS) : cfg_win;
        floor_off = REGION_END - ((CFG_AW + 1)'(steps) << STEP_LOG2);
        win_hit   = ({1'b0, cfg_off} >= floor_off);

        case (region)
            RG_MAIN: deny = 1'b0;
            RG_CUST: deny = is_read ? win_hit : aux[AUX_CUST];
            RG_FACT: deny = !is_read && aux[AUX_FACT];
            RG_ENGR: deny = !is_read && aux[AUX_ENGR];
            RG_SECR: deny = !is_read && aux[AUX_SECR];
            RG_LOG:  deny = is_read ? log_rd : aux[AUX_LOG];
            default: deny = 1'b1;
        endcase
    end

endmodule

// File: rtl/flash_prot_chk.sv
module flash_prot_chk
    import flash_prot_pkg::*;
#(
    parameter int SECT_LOG2          = 11,
    parameter int SECT_PER_BANK_LOG2 = 8,
    parameter int GRP_LOG2           = 3,
    parameter int RD_MAX_UNITS       = 8,
    parameter int LOW_GRP_SKIP       = 4,
    parameter int CFG_AW             = 11,
    parameter int STEP_LOG2          = 4,
    parameter int WIN_STEPS          = 32,
    parameter int ADDR_W             = SECT_LOG2 + SECT_PER_BANK_LOG2 + 1
)(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [SEL_W-1:0]    wr_sel,
    input  logic [WORD_W-1:0]   wr_data,
    input  logic                split_mode,
    input  logic                swap,
    input  logic                req_valid,
    input  logic [OP_W-1:0]     req_op,
    input  logic [REGION_W-1:0] req_region,
    input  logic [ADDR_W-1:0]   req_addr,
    output logic                deny
);

    prot_regs_t regs_q;
    logic       is_read;
    logic       main_deny;
    logic       cfg_deny;

    assign is_read = (req_op == OP_READ);

    flash_prot_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .regs_q  (regs_q)
    );

    flash_prot_main #(
        .SECT_LOG2          (SECT_LOG2),
        .SECT_PER_BANK_LOG2 (SECT_PER_BANK_LOG2),
        .GRP_LOG2           (GRP_LOG2),
        .RD_MAX_UNITS       (RD_MAX_UNITS),
        .LOW_GRP_SKIP       (LOW_GRP_SKIP),
        .ADDR_W             (ADDR_W)
    ) u_main (
        .addr       (req_addr),
        .is_read    (is_read),
        .split_mode (split_mode),
        .swap       (swap),
        .main_rd    (regs_q.main_rd),
        .sect_prot  (regs_q.sect),
        .grp0_prot  (regs_q.grp0),
        .grp1_prot  (regs_q.grp1),
        .deny       (main_deny)
    );

    flash_prot_cfg #(
        .CFG_AW    (CFG_AW),
        .STEP_LOG2 (STEP_LOG2),
        .WIN_STEPS (WIN_STEPS)
    ) u_cfg (
        .cfg_off (req_addr[CFG_AW-1:0]),
        .is_read (is_read),
        .region  (req_region),
        .cfg_win (regs_q.cfg_win),
        .log_rd  (regs_q.log_rd),
        .aux     (regs_q.aux),
        .deny    (cfg_deny)
    );

    assign deny = req_valid && ((req_region == RG_MAIN) ? main_deny : cfg_deny);

endmodule

// File: rtl/flash_prot_chk_sva.sv
module flash_prot_chk_sva
    import flash_prot_pkg::*;
#(
    parameter int ADDR_W  = 20,
    parameter int RD_UNIT = 2048
)(
    input logic                clk,
    input logic                rst_n,
    input logic                wr_en,
    input logic                req_valid,
    input logic [OP_W-1:0]     req_op,
    input logic [REGION_W-1:0] req_region,
    input logic [ADDR_W-1:0]   req_addr,
    input logic                deny,
    input prot_regs_t          regs
);

    logic [REGS_W-1:0] rv;
    assign rv = regs;

    // R2: no protection bit ever rises after reset
    a_r2_clear_only: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((rv & ~$past(rv)) == '0));

    // R12: without a write strobe the state holds
    a_r12_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(rv));

    // R3: first read unit is denied whenever any read window is configured
    a_r3_first_unit: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_region == 3'd0 && req_op == 2'd0 &&
         regs.main_rd != '0 && int'(req_addr) < RD_UNIT) |-> deny);

    // R11: idle request port never denies
    a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |-> !deny);

    // R11: unknown region codes are denied
    a_r11_bad_region: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_region >= 3'd6) |-> deny);

    // R11: reads of factory, engineering and secure regions pass
    a_r11_open_read: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == 2'd0 && req_region >= 3'd2 && req_region <= 3'd4) |-> !deny);

endmodule

bind flash_prot_chk flash_prot_chk_sva #(.ADDR_W(ADDR_W)) u_sva (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .req_valid  (req_valid),
    .req_op     (req_op),
    .req_region (req_region),
    .req_addr   (req_addr),
    .deny       (deny),
    .regs       (regs_q)
);

// File: tb/flash_prot_chk_tb.sv
module flash_prot_chk_tb;

    localparam int AW = 20;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [2:0]    wr_sel = '0;
    logic [31:0]   wr_data = '0;
    logic          split_mode = 1'b0;
    logic          swap = 1'b0;
    logic          req_valid = 1'b0;
    logic [1:0]    req_op = '0;
    logic [2:0]    req_region = '0;
    logic [AW-1:0] req_addr = '0;
    logic          deny;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    logic [31:0] m [0:5];

    always #5 clk = ~clk;

    flash_prot_chk u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_sel     (wr_sel),
        .wr_data    (wr_data),
        .split_mode (split_mode),
        .swap       (swap),
        .req_valid  (req_valid),
        .req_op     (req_op),
        .req_region (req_region),
        .req_addr   (req_addr),
        .deny       (deny)
    );

    function automatic bit ref_deny(bit v, int op, int rg, int a, bit sp, bit sw);
        int n, lb, pb, sec, grp, off;
        if (!v) return 0;
        case (rg)
            0: begin
                if (op == 0) begin
                    n = int'(m[0]);
                    if (n > 8) n = 8;
                    return a < n * 2048;
                end
                lb  = a >> 19;
                pb  = lb ^ int'(sp & sw);
                sec = (a >> 11) & 255;
                grp = sec >> 3;
                if (lb == 0 && sec < 32 && m[2][sec]) return 1;
                if (lb == 0 && grp < 4) return 0;
                return m[3 + pb][grp];
            end
            1: begin
                if (op != 0) return m[5][0];
                n = int'(m[1] & 63);
                if (n > 32) n = 32;
                off = a & 2047;
                return off >= 2048 - n * 16;
            end
            2: return op != 0 && m[5][1];
            3: return op != 0 && m[5][2];
            4: return op != 0 && m[5][3];
            5: return (op == 0) ? m[1][6] : m[5][4];
            default: return 1;
        endcase
    endfunction

    task automatic model_write(int sel, logic [31:0] d);
        if (sel < 6) m[sel] = m[sel] & d;
    endtask

    task automatic compare(bit exp, string tag);
        checks++;
        if (deny !== exp) begin
            failures++;
            $display("FAIL %s deny=%0b expected=%0b", tag, deny, exp);
        end
    endtask

    task automatic probe(bit v, int op, int rg, int a, string tag);
        @(negedge clk);
        req_valid  = v;
        req_op     = op[1:0];
        req_region = rg[2:0];
        req_addr   = a[AW-1:0];
        #1;
        compare(ref_deny(v, op, rg, a, split_mode, swap), tag);
    endtask

    task automatic reg_write(int sel, logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1;
        wr_sel = sel[2:0];
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        model_write(sel, d);
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        m[0] = 32'hF; m[1] = 32'h7F; m[2] = '1; m[3] = '1; m[4] = '1; m[5] = 32'h1F;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        probe(0, 0, 0, 0, "R11 idle");
        probe(1, 0, 0, 0, "R1 main read low");
        probe(1, 0, 0, 16383, "R1 main read top of window");
        probe(1, 0, 0, 16384, "R3 read beyond window");
        probe(1, 1, 0, 32'h9C000, "R1 bank1 program");
        probe(1, 2, 0, 32'h40000, "R1 bank0 erase high group");
        probe(1, 0, 1, 1536, "R1 cfg read window start");
        probe(1, 0, 1, 1535, "R4 cfg read below window");
        probe(1, 0, 5, 0, "R1 log read");
        probe(1, 1, 4, 0, "R1 secure program");

        // R3 read window encodings
        reg_write(0, 32'h9);
        probe(1, 0, 0, 16383, "R3 undefined code 9");
        reg_write(0, 32'h5);
        probe(1, 0, 0, 2047, "R3 n=1 inside");
        probe(1, 0, 0, 2048, "R3 n=1 outside");
        reg_write(0, 32'hF);
        probe(1, 0, 0, 2048, "R2 written ones do not re-protect");
        reg_write(0, 32'h0);
        probe(1, 0, 0, 0, "R3 n=0 open");

        // R4 / R5 configuration window and log bit
        reg_write(1, 32'h43);
        probe(1, 0, 1, 2000, "R4 n=3 first protected");
        probe(1, 0, 1, 1999, "R4 n=3 open");
        probe(1, 0, 5, 0, "R5 log still protected");
        reg_write(1, 32'h03);
        probe(1, 0, 5, 0, "R5 log cleared");
        probe(1, 1, 1, 2047, "R10 cust program bit0");

        // R6 / R8 sector register and low-group exemption
        probe(1, 1, 0, 32'h2800, "R6 sector5 protected");
        reg_write(2, ~(32'h1 << 5));
        probe(1, 1, 0, 32'h2800, "R8 sector5 open, group0 ignored");
        probe(1, 1, 0, 32'h3000, "R6 sector6 still protected");
        // R7 group register
        probe(1, 2, 0, 32'h14000, "R7 group5 bank0 protected");
        reg_write(3, ~(32'h1 << 5));
        probe(1, 2, 0, 32'h14000, "R7 group5 bank0 cleared");

        // R9 swap without split mode
        @(negedge clk); split_mode = 1'b0; swap = 1'b1;
        probe(1, 1, 0, 32'h94000, "R9 swap ignored logical1");
        probe(1, 1, 0, 32'h14000, "R9 swap ignored logical0");
        // R7 / R8 with swap active
        @(negedge clk); split_mode = 1'b1;
        probe(1, 1, 0, 32'h14000, "R7 swapped logical0 to bank1");
        probe(1, 1, 0, 32'h94000, "R7 swapped logical1 to bank0");
        probe(1, 1, 0, 32'h02800, "R8 bank1 as logical0 low group ignored");
        probe(1, 1, 0, 32'h82800, "R8 bank0 as logical1 low group applies");
        reg_write(4, 32'hFFFF_FFFE);
        probe(1, 1, 0, 32'h02800, "R8 after bank1 group0 clear");

        // R10 auxiliary bits
        probe(1, 2, 3, 0, "R10 engr protected");
        reg_write(5, 32'h1B);
        probe(1, 2, 3, 0, "R10 engr cleared");
        probe(1, 2, 4, 0, "R10 secure still protected");

        // R11 region classes
        probe(1, 0, 2, 100, "R11 factory read open");
        probe(1, 0, 6, 0, "R11 code6 denied");
        probe(1, 3, 7, 0, "R11 code7 denied");

        // R12 unused selects
        reg_write(6, 32'h0);
        reg_write(7, 32'h0);
        probe(1, 1, 4, 0, "R12 secure unaffected");
        probe(1, 1, 0, 32'h3000, "R12 sector6 unaffected");

        // randomized phase against the model every cycle
        for (int i = 0; i < 3000; i++) begin
            int a;
            int sel;
            logic [31:0] d;
            bit w;
            @(negedge clk);
            split_mode = 1'($urandom);
            swap       = 1'($urandom);
            req_valid  = ($urandom % 8) != 0;
            req_op     = 2'($urandom);
            req_region = 3'($urandom);
            a = int'($urandom & 32'hFFFFF);
            if ($urandom % 2) a = a & 32'h8_FFFF;
            req_addr = a[AW-1:0];
            w   = ($urandom % 16) == 0;
            sel = int'($urandom % 8);
            d   = ~(32'h1 << ($urandom % 32));
            wr_en = w; wr_sel = sel[2:0]; wr_data = d;
            #1;
            compare(ref_deny(req_valid, int'(req_op), int'(req_region), a, split_mode, swap),
                    "R7 random mix");
            if (w) model_write(sel, d);
        end
        @(negedge clk);
        wr_en = 1'b0;
        req_valid = 1'b0;

        done = 1;
        summary();
        $finish;
    end

endmodule